// File: doc/BRIEF.md
# Set/Clear General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port that sits on a simple memory-mapped register bus. Software never writes output levels directly. It writes a mask to a drive-high register or to a drive-low register. Every pin whose mask bit is 1 takes the new level, and as a side effect it becomes an output. Pins whose mask bit is 0 keep their level and their direction. A third register releases pins. Writing a 1 to a bit there turns that pin's driver off, so the pin becomes an input again.

The live level of every pad goes through a two-flop synchroniser and can be read from a level register. That readback stays at zero until software has written the input-arm register once, whatever value it writes. After that first write the readback stays enabled until reset. Each pad is brought out as three separate signals: an input, an output value and an output enable. Pin n always corresponds to bit n of every register.

Register offsets (word addresses on `bus_addr`):
- 0: drive-high
- 1: drive-low
- 2: release
- 3: input-arm
- 4: level, read-only

Offsets 5 to 7 are unmapped.

Top module: `gpsc_port`

## Requirements
- R1: After reset every `pad_oe` bit is 0, every `pad_out` bit is 0, and a read of offset 4 returns 0.
- R2: A write of mask M to offset 0 sets `pad_out` bits where M is 1, at the clock edge that samples `bus_wr`, and leaves the other `pad_out` bits unchanged.
- R3: A write of mask M to offset 1 clears `pad_out` bits where M is 1, at the clock edge that samples `bus_wr`, and leaves the other `pad_out` bits unchanged.
- R4: A write to offset 0 or offset 1 sets `pad_oe` bit n for every mask bit n that is 1 and leaves the other `pad_oe` bits unchanged.
- R5: A write of mask M to offset 2 clears `pad_oe` bits where M is 1 and changes no `pad_out` bit and no other `pad_oe` bit.
- R6: Reads of offset 4 return 0 until offset 3 has been written at least once, with any data value. From the edge after that write until reset, they return the synchronised pad levels.
- R7: A change on `pad_in` shows in the offset-4 readback after exactly two rising clock edges, not after one.
- R8: Reads of offsets 0 to 3 and 5 to 7 return 0. A write to offset 4 or to offsets 5 to 7 changes neither `pad_out` nor `pad_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is combinational |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data / mask |
| bus_rdata | output | 32 | Read data |
| pad_in | input | 32 | Level seen at each pad |
| pad_out | output | 32 | Output level latched for each pad |
| pad_oe | output | 32 | Output enable per pad; 1 means driven |

## Verification
The embedded properties are checked on every cycle:
- at most one write strobe is decoded at a time;
- set, clear and release writes move only the masked bits, and the write that moves them is the one sampled at that edge;
- the output and enable flops hold steady on cycles without a write;
- the input-arm flag never falls after it is set, and readback is zero while it is low;
- each synchroniser stage copies the stage before it.

The bench scenarios cover the rest:
- the exact two-edge latency seen at the read port;
- the fact that the data written to the input-arm register is irrelevant;
- that reads of write-only and unmapped offsets return zero;
- the per-pin mapping, through a sweep of all 32 pins and a long mixed sequence of set, clear and release writes checked against an arithmetic model of the pads.

// File: rtl/gpsc_pkg.sv
package gpsc_pkg;

  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    OFS_DRV_HI  = 3'd0,
    OFS_DRV_LO  = 3'd1,
    OFS_RELEASE = 3'd2,
    OFS_ARM_IN  = 3'd3,
    OFS_LEVEL   = 3'd4
  } reg_ofs_e;

  typedef struct packed {
    logic drv_hi;
    logic drv_lo;
    logic release_pins;
    logic arm_in;
    logic sel_level;
  } dec_s;

endpackage

// File: rtl/gpsc_decode.sv
module gpsc_decode
  import gpsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  output dec_s              dec
);

  function automatic logic hit(input logic [REG_AW-1:0] a, input reg_ofs_e o);
    return a == o;
  endfunction

  always_comb begin
    dec.drv_hi       = bus_wr & hit(bus_addr, OFS_DRV_HI);
    dec.drv_lo       = bus_wr & hit(bus_addr, OFS_DRV_LO);
    dec.release_pins = bus_wr & hit(bus_addr, OFS_RELEASE);
    dec.arm_in       = bus_wr & hit(bus_addr, OFS_ARM_IN);
    dec.sel_level    = bus_rd & hit(bus_addr, OFS_LEVEL);
  end

  // R8: a single write never decodes to two write strobes
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec.drv_hi, dec.drv_lo, dec.release_pins, dec.arm_in}));

endmodule

// File: rtl/gpsc_drive.sv
module gpsc_drive #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_hi,
  input  logic             stb_lo,
  input  logic             stb_rel,
  input  logic [NPINS-1:0] mask,
  output logic [NPINS-1:0] out_q,
  output logic [NPINS-1:0] oe_q
);

  function automatic logic [NPINS-1:0] next_level(
    input logic [NPINS-1:0] cur, input logic [NPINS-1:0] m,
    input logic hi, input logic lo);
    logic [NPINS-1:0] r;
    r = cur;
    if (hi) r = r | m;
    if (lo) r = r & ~m;
    return r;
  endfunction

  function automatic logic [NPINS-1:0] next_enable(
    input logic [NPINS-1:0] cur, input logic [NPINS-1:0] m,
    input logic grab, input logic rel);
    logic [NPINS-1:0] r;
    r = cur;
    if (grab) r = r | m;
    if (rel)  r = r & ~m;
    return r;
  endfunction

  logic any_drive;
  assign any_drive = stb_hi | stb_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      out_q <= next_level(out_q, mask, stb_hi, stb_lo);
      oe_q  <= next_enable(oe_q, mask, any_drive, stb_rel);
    end
  end

  // R2: masked bits rise, others hold
  p_set_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_hi |=> ((out_q & $past(mask)) == $past(mask)) &&
               ((out_q & ~$past(mask)) == ($past(out_q) & ~$past(mask))));
  // R3: masked bits fall, others hold
  p_clr_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stb_lo |=> ((out_q & $past(mask)) == '0) &&
               ((out_q & ~$past(mask)) == ($past(out_q) & ~$past(mask))));
  // R4: driving a level makes the masked pins outputs
  p_drive_grabs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_hi || stb_lo) |=> ((oe_q & $past(mask)) == $past(mask)) &&
                           ((oe_q & ~$past(mask)) == ($past(oe_q) & ~$past(mask))));
  // R5: release drops enables only
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rel |=> ((oe_q & $past(mask)) == '0) && $stable(out_q) &&
                ((oe_q & ~$past(mask)) == ($past(oe_q) & ~$past(mask))));
  // R8: no decoded write, nothing moves
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb_hi || stb_lo || stb_rel) |=> $stable(out_q) && $stable(oe_q));

endmodule

// File: rtl/gpsc_sync.sv
module gpsc_sync #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] d,
  output logic [NPINS-1:0] q
);

  logic [NPINS-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= '0;
      else        stage_q[i] <= stage_q[i-1];
    end
    // R7: each stage is one clock behind the previous one
    p_stage_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stage_q[i] == $past(stage_q[i-1]));
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpsc_sense.sv
module gpsc_sense #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_arm,
  input  logic             sel_level,
  input  logic [NPINS-1:0] synced,
  output logic [NPINS-1:0] rdata
);

  logic             armed_q;
  logic [NPINS-1:0] level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (stb_arm) armed_q <= 1'b1;
  end

  function automatic logic [NPINS-1:0] gate_level(
    input logic [NPINS-1:0] s, input logic en);
    return en ? s : '0;
  endfunction

  assign level = gate_level(synced, armed_q);
  assign rdata = sel_level ? level : '0;

  // R6: once armed, stays armed
  p_arm_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
  // R6: arming follows an arm strobe
  p_arm_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(stb_arm));
  // R6: unarmed readback is zero
  p_gate_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> rdata == '0);

endmodule

// File: rtl/gpsc_port.sv
module gpsc_port
  import gpsc_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);

  dec_s             dec;
  logic [NPINS-1:0] synced;

  gpsc_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .dec      (dec)
  );

  gpsc_drive #(.NPINS(NPINS)) u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb_hi  (dec.drv_hi),
    .stb_lo  (dec.drv_lo),
    .stb_rel (dec.release_pins),
    .mask    (bus_wdata),
    .out_q   (pad_out),
    .oe_q    (pad_oe)
  );

  gpsc_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (synced)
  );

  gpsc_sense #(.NPINS(NPINS)) u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_arm   (dec.arm_in),
    .sel_level (dec.sel_level),
    .synced    (synced),
    .rdata     (bus_rdata)
  );

  // R8: only the level offset ever returns nonzero data
  p_wo_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != OFS_LEVEL) |-> bus_rdata == '0);
  // R1: first cycle out of reset the pads are released and low
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0) && (pad_out == '0));

endmodule

// File: tb/tb_gpsc_port.sv
module tb_gpsc_port;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  pad_in;
  logic [N-1:0]  pad_out;
  logic [N-1:0]  pad_oe;
  logic [N-1:0]  ext = 32'hA5A5_0F0F;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [N-1:0] m_out = '0;
  logic [N-1:0] m_oe = '0;
  bit           m_arm = 0;

  always #2 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpsc_port dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      3'd0: begin m_out = m_out | d; m_oe = m_oe | d; end
      3'd1: begin m_out = m_out & ~d; m_oe = m_oe | d; end
      3'd2: m_oe = m_oe & ~d;
      3'd3: m_arm = 1;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  function automatic logic [N-1:0] exp_level();
    logic [N-1:0] pads;
    pads = (m_oe & m_out) | (~m_oe & ext);
    return m_arm ? pads : '0;
  endfunction

  task automatic settle_and_read(input string tag);
    logic [N-1:0] v;
    repeat (3) @(negedge clk);
    rd(3'd4, v);
    chk(tag, v, exp_level());
  endtask

  initial begin
    logic [N-1:0] v;
    logic [N-1:0] lcg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe after reset", pad_oe, '0);
    chk("R1 out after reset", pad_out, '0);
    rd(3'd4, v);
    chk("R1 level after reset", v, '0);

    settle_and_read("R6 unarmed level zero");

    for (int a = 0; a < 8; a++) begin
      if (a != 4) begin
        rd(a[2:0], v);
        chk("R8 write-only read zero", v, '0);
      end
    end

    wr(3'd3, 32'h0000_0000);
    settle_and_read("R6 armed by zero write");
    wr(3'd3, 32'hFFFF_FFFF);
    settle_and_read("R6 rearm keeps level");

    // R7 latency: change at negedge, visible after two rising edges
    @(negedge clk);
    ext = 32'h1234_5678;
    rd(3'd4, v);
    chk("R7 before any edge", v, 32'hA5A5_0F0F);
    @(negedge clk);
    rd(3'd4, v);
    chk("R7 after one edge", v, 32'hA5A5_0F0F);
    @(negedge clk);
    rd(3'd4, v);
    chk("R7 after two edges", v, 32'h1234_5678);

    for (int n = 0; n < N; n++) begin
      logic [N-1:0] bit_m;
      bit_m = 32'd1 << n;
      wr(3'd0, bit_m);
      chk("R2 sweep out", pad_out, m_out);
      chk("R4 sweep oe", pad_oe, m_oe);
    end
    settle_and_read("R2 all driven high read");
    for (int n = 0; n < N; n += 2) begin
      logic [N-1:0] bit_m;
      bit_m = 32'd1 << n;
      wr(3'd1, bit_m);
      chk("R3 sweep out", pad_out, m_out);
      chk("R4 sweep oe after clear", pad_oe, m_oe);
    end
    for (int n = 1; n < N; n += 4) begin
      logic [N-1:0] bit_m;
      bit_m = 32'd1 << n;
      wr(3'd2, bit_m);
      chk("R5 sweep oe", pad_oe, m_oe);
      chk("R5 sweep out kept", pad_out, m_out);
    end
    settle_and_read("R5 released pins read ext");

    for (int a = 4; a < 8; a++) begin
      wr(a[2:0], 32'hFFFF_FFFF);
      chk("R8 ignored write out", pad_out, m_out);
      chk("R8 ignored write oe", pad_oe, m_oe);
    end

    lcg = 32'h1ACE_B00C;
    for (int i = 0; i < 60; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      wr({1'b0, (lcg[1:0] == 2'd3) ? 2'd2 : lcg[1:0]}, lcg ^ {lcg[15:0], lcg[31:16]});
      chk("R2 R3 mixed out", pad_out, m_out);
      chk("R4 R5 mixed oe", pad_oe, m_oe);
      if (i % 6 == 0) begin
        ext = ~lcg;
        settle_and_read("R7 mixed level");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule